// File: doc/BRIEF.md
# Toggle-Handshake Pipeline Controller

This block is the per-stage control for a bundled-data pipeline. Stages exchange two-phase handshakes: a request or acknowledge event is any change of level on its wire, rising or falling. The model is synchronous. The toggle levels are sampled on a system clock, and each stage's decision is a clocked Muller C-element.

Each stage holds one data word. A stage's C-element compares the request phase arriving from upstream with the inverted acknowledge phase arriving from downstream. When the two agree and differ from the element's stored output, the stage fires. Firing flips its outgoing request, which also serves as its acknowledge to the upstream stage, and loads the upstream word into its register.

A producer injects a word by placing it on the data input and toggling the input request. The word is taken when the input acknowledge matches the request again. A consumer sees a result whenever the output request differs from its own acknowledge, and it releases that result by toggling the acknowledge. The stage count and the data width are parameters.

Top module: `toggle_pipe_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `in_ack` and `out_req` are 0, so the pipeline starts empty.
- R2: A falling toggle of `in_req` injects a word just as a rising toggle does.
- R3: When the first stage is empty, `in_ack` takes the value of `in_req` one clock after `in_req` is toggled.
- R4: In an empty pipeline, `out_req` toggles exactly STAGES clocks after an `in_req` toggle, and it does not toggle before then.
- R5: A stage fires only when its upstream has an unconsumed word and its downstream has taken the previous one. With a consumer that never acknowledges, exactly STAGES words are accepted, and any further request stays unanswered (`in_ack` differs from `in_req`).
- R6: Each stage's C-element copies its inputs when they agree (request phase equal to the inverted acknowledge phase) and holds its value when they disagree.
- R7: While `out_req` differs from `out_ack`, `out_data` and `out_req` stay unchanged.
- R8: Every accepted word leaves exactly once, in the order of entry, under fast, slow and stalled consumers.
- R9: `in_ack` changes only in a cycle that follows one in which `in_req` differed from `in_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the handshake levels |
| rst_n | input | 1 | Active-low synchronous reset |
| in_req | input | 1 | Producer request phase; each toggle offers a word |
| in_ack | output | 1 | Acknowledge phase to the producer |
| in_data | input | WIDTH | Word offered with the pending request |
| out_req | output | 1 | Result request phase; each toggle presents a word |
| out_ack | input | 1 | Consumer acknowledge phase; each toggle releases a word |
| out_data | output | WIDTH | Word presented by the last stage |

## Verification
The bench first sends single words into an empty pipeline with the consumer held off, once on a rising and once on a falling request edge. This measures the acknowledge and traversal delays exactly and shows that both toggle directions are events. Back-to-back bursts then run against a consumer that acknowledges at once and against one that acknowledges only every third cycle. These separate correct flow control from losses and duplications that appear only when stages fire in the same cycle. Last, a consumer that never acknowledges lets the pipeline fill. This shows where acceptance stops, that the presented result holds still, and that release drains the words in order.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

  // Next state of a Muller C-element: follow agreeing inputs, else hold.
  function automatic logic celem_next(input logic a, input logic b, input logic q);
    return (a == b) ? a : q;
  endfunction

  // A two-phase link carries an unconsumed event when its phases differ.
  function automatic logic link_pending(input logic req_ph, input logic ack_ph);
    return req_ph ^ ack_ph;
  endfunction

endpackage

// File: rtl/tpc_celem.sv
module tpc_celem (
  input  logic clk,
  input  logic rst_n,
  input  logic a,
  input  logic b,
  output logic q,
  output logic q_nxt
);
  import tpc_pkg::*;

  assign q_nxt = celem_next(a, b, q);

  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/tpc_stage.sv
module tpc_stage #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_in,
  input  logic             ack_in,
  input  logic [WIDTH-1:0] d_in,
  output logic             req_out,
  output logic             fire,
  output logic [WIDTH-1:0] q_data
);
  logic c_nxt;

  tpc_celem u_c (
    .clk   (clk),
    .rst_n (rst_n),
    .a     (req_in),
    .b     (~ack_in),
    .q     (req_out),
    .q_nxt (c_nxt)
  );

  // Any change of the control phase, in either direction, loads one word.
  assign fire = c_nxt ^ req_out;

  always_ff @(posedge clk) begin
    if (!rst_n)    q_data <= '0;
    else if (fire) q_data <= d_in;
  end
endmodule

// File: rtl/toggle_pipe_ctrl.sv
module toggle_pipe_ctrl #(
  parameter int STAGES = 4,
  parameter int WIDTH  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_req,
  output logic             in_ack,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_req,
  input  logic             out_ack,
  output logic [WIDTH-1:0] out_data
);
  localparam int LAST = STAGES - 1;

  // Named per-stage events for the checker.
  logic [STAGES-1:0] st_req_in;
  logic [STAGES-1:0] st_ack_in;
  logic [STAGES-1:0] st_ph;
  logic [STAGES-1:0] st_fire;
  logic [WIDTH-1:0]  st_d_in [STAGES];
  logic [WIDTH-1:0]  st_q    [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign st_req_in[i] = in_req;
      assign st_d_in[i]   = in_data;
    end else begin : g_body
      assign st_req_in[i] = st_ph[i-1];
      assign st_d_in[i]   = st_q[i-1];
    end

    if (i == LAST) begin : g_tail
      assign st_ack_in[i] = out_ack;
    end else begin : g_mid
      assign st_ack_in[i] = st_ph[i+1];
    end

    tpc_stage #(.WIDTH(WIDTH)) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_in  (st_req_in[i]),
      .ack_in  (st_ack_in[i]),
      .d_in    (st_d_in[i]),
      .req_out (st_ph[i]),
      .fire    (st_fire[i]),
      .q_data  (st_q[i])
    );
  end

  assign in_ack   = st_ph[0];
  assign out_req  = st_ph[LAST];
  assign out_data = st_q[LAST];
endmodule

// File: rtl/tpc_checker.sv
module tpc_checker #(
  parameter int STAGES = 4,
  parameter int WIDTH  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_req,
  input logic              in_ack,
  input logic              out_req,
  input logic              out_ack,
  input logic [WIDTH-1:0]  out_data,
  input logic [STAGES-1:0] st_req_in,
  input logic [STAGES-1:0] st_ack_in,
  input logic [STAGES-1:0] st_ph
);

  p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!in_ack && !out_req));

  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req != out_ack) |=> ($stable(out_data) && $stable(out_req)));

  p_ack_answers_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(in_ack) |-> $past(in_req != in_ack));

  for (genvar i = 0; i < STAGES; i++) begin : g_chk
    p_c_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_req_in[i] == ~st_ack_in[i]) |=> (st_ph[i] == $past(st_req_in[i])));

    p_c_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_req_in[i] != ~st_ack_in[i]) |=> $stable(st_ph[i]));
  end
endmodule

bind toggle_pipe_ctrl tpc_checker #(.STAGES(STAGES), .WIDTH(WIDTH)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_req    (in_req),
  .in_ack    (in_ack),
  .out_req   (out_req),
  .out_ack   (out_ack),
  .out_data  (out_data),
  .st_req_in (st_req_in),
  .st_ack_in (st_ack_in),
  .st_ph     (st_ph)
);

// File: tb/toggle_pipe_ctrl_tb_top.sv
module toggle_pipe_ctrl_tb_top;
  localparam int N = 4;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_req = 1'b0;
  logic         out_ack = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         in_ack, out_req;
  logic [W-1:0] out_data;

  int n_chk = 0;
  int n_bad = 0;
  logic stall = 1'b1;
  logic slow  = 1'b0;
  int slow_cnt = 0;
  int acc_cnt = 0;
  logic ack_prev = 1'b0;
  logic [W-1:0] exp_q[$];

  always #10 clk = ~clk;

  toggle_pipe_ctrl #(.STAGES(N), .WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_ack(in_ack),
    .in_data(in_data), .out_req(out_req), .out_ack(out_ack), .out_data(out_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // Driver: wait until the previous word is taken, then offer the next one.
  task automatic send(input logic [W-1:0] w);
    while (in_ack != in_req) @(negedge clk);
    in_data = w;
    in_req  = ~in_req;
    exp_q.push_back(w);
  endtask

  // Count accepted words (input acknowledge events).
  initial forever begin
    @(negedge clk);
    if (in_ack != ack_prev) acc_cnt++;
    ack_prev = in_ack;
  end

  // Monitor / scoreboard: R8 ordering, no loss, no duplicate.
  initial forever begin
    @(negedge clk);
    if (rst_n && !stall && (out_req != out_ack)) begin
      slow_cnt++;
      if (!slow || (slow_cnt % 3 == 0)) begin
        if (exp_q.size() == 0) check("R8 extra word", 32'(out_data), 32'hFFFF_FFFF);
        else check("R8 order", 32'(out_data), 32'(exp_q.pop_front()));
        out_ack = ~out_ack;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  task automatic latency_probe(input logic [W-1:0] w, input string tag);
    @(negedge clk);
    in_data = w;
    in_req  = ~in_req;
    exp_q.push_back(w);
    @(negedge clk);
    check({"R3 ack follows ", tag}, 32'(in_ack), 32'(in_req));
    repeat (N - 2) @(negedge clk);
    check({"R4 not early ", tag}, 32'(out_req != out_ack), 32'd0);
    @(negedge clk);
    check({"R4 arrives ", tag}, 32'(out_req != out_ack), 32'd1);
    check({"R2 data ", tag}, 32'(out_data), 32'(w));
  endtask

  task automatic drain();
    int t;
    t = 0;
    while (exp_q.size() != 0 && t < 2000) begin @(negedge clk); t++; end
    check("R8 drained", 32'(exp_q.size()), 32'd0);
  endtask

  initial begin
    logic [W-1:0] held;
    repeat (3) @(negedge clk);
    check("R1 in_ack reset", 32'(in_ack), 32'd0);
    check("R1 out_req reset", 32'(out_req), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 empty after", 32'(in_ack ^ out_req), 32'd0);

    // R3/R4 with a rising toggle, then R2 with a falling toggle.
    latency_probe(8'hA5, "rise");
    stall = 1'b0; drain(); stall = 1'b1;
    latency_probe(8'h3C, "fall");
    stall = 1'b0; drain();

    // Fast consumer burst.
    for (int i = 0; i < 20; i++) send(W'(i * 37 + 5));
    drain();

    // Slow consumer burst.
    slow = 1'b1;
    for (int i = 0; i < 15; i++) send((i % 2) ? 8'h55 : 8'hAA);
    send(8'hFF); send(8'h00);
    drain();
    slow = 1'b0;

    // Stalled consumer fills the pipeline (R5), result held (R7).
    stall = 1'b1;
    @(negedge clk);
    acc_cnt = 0;
    for (int i = 0; i <= N; i++) send(W'(8'h10 + i));
    repeat (4 * N) @(negedge clk);
    check("R5 accepted count", 32'(acc_cnt), 32'(N));
    check("R5 extra unanswered", 32'(in_ack != in_req), 32'd1);
    check("R7 result pending", 32'(out_req != out_ack), 32'd1);
    held = out_data;
    check("R7 head word", 32'(held), 32'h10);
    repeat (5) @(negedge clk);
    check("R7 data stable", 32'(out_data), 32'(held));
    stall = 1'b0;
    drain();
    repeat (2 * N) @(negedge clk);
    check("R8 none left", 32'(out_req != out_ack), 32'd0);
    finish_run();
  end
endmodule